// File: doc/BRIEF.md
# Double-Buffered Audio PWM Timer

This block turns a stream of PCM samples into a pulse-width-modulated output. A free-running up-counter sweeps from 0 to a programmed period value and then wraps. The output goes high at each wrap and falls once the counter passes the active sample value. Software or a DMA engine places the next sample in a staging register. The block copies it into a working register when the timer is started, and again after a programmable number of periods. This lets one sample be held for several periods when the sample rate is lower than the PWM rate.

Each copy sets a sticky "sample consumed" flag. It also raises a request line that can drive a DMA channel directly, so a refill does not need an interrupt. A second sticky flag marks the point where the counter reaches the sample's compare point. Two resolutions are offered. In normal resolution one sample unit is one clock. In fine resolution one unit is half a clock, and the falling edge may land on either clock phase. An 8-bit sample format takes the sample from the upper byte of the staging register.

Top module: `apwm_timer`

Register map (word addresses on `regAddr`): 0 = sample staging (R/W), 1 = period staging (R/W), 2 = live counter (read only), 3 = mode, 4 = flags and enables. The mode word has these fields: bit 0 run, bit 1 fine resolution, bit 2 8-bit format, bits 7:4 hold the hold count minus one. The flags word has these fields: bit 0 consumed flag, bit 1 compare flag, bit 8 consumed-interrupt enable, bit 9 compare-interrupt enable. Writing 1 to bit 0 or bit 1 clears that flag. The enable bits take the written value.

## Requirements
- R1: After reset `pwmOut`, `irqOut` and `dmaReq` are low and the live counter reads 0.
- R2: Writing run = 1 while stopped copies the sample and period staging values into the working registers one clock later. That same edge sets the consumed flag (flags bit 0), raises `dmaReq` and restarts the counter at 0.
- R3: While running, the counter counts 0, 1, …, P and wraps to 0, so a period is P+1 clocks, where P is the working period. The period staging value is copied into the working period at every wrap, so a mid-period write takes effect only at the next wrap.
- R4: In normal resolution the output is high for min(S, P+1) clocks of every period, where S is the working sample. The output lags the counter by one clock.
- R5: In fine resolution the output is high for min(S, 2·(P+1)) half-clock intervals of every period.
- R6: With the 8-bit format (mode bit 2), S is bits 15:8 of the working sample, and bits 7:0 have no effect.
- R7: While running, the sample is copied again after every N-th wrap, where N = mode[7:4] + 1 (range 1 to 16). Every copy sets the consumed flag and raises `dmaReq`.
- R8: A write to the sample staging register drops `dmaReq`. If that write lands on the same edge as a copy, the copy takes the old staging value, `dmaReq` ends low, the consumed flag is set, and the new value stays staged for the next copy.
- R9: The compare flag (flags bit 1) is set when the counter equals S in normal resolution, or S>>1 in fine resolution. It is never set when the 8-bit format is selected.
- R10: The flags are sticky and are cleared by writing 1 to them. `irqOut` is high exactly when some flag is set and its enable (bit 8 for consumed, bit 9 for compare) is 1.
- R11: Writing run = 0 resets the counter to 0 and holds `pwmOut` low from the second clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output also changes on its falling edge in fine resolution |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address for writes and reads |
| regWe | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| pwmOut | output | 1 | Pulse-width-modulated audio output |
| irqOut | output | 1 | Interrupt, OR of the enabled sticky flags |
| dmaReq | output | 1 | Refill request, set by each sample copy, cleared by a sample write |

## Verification
Two events can fall in the same cycle: a sample copy at a period boundary and a software or DMA write to the sample staging register. The bench locks onto a copy through the rising `dmaReq`. It counts clocks to the next scheduled copy, and it times a sample write to land on exactly that edge. The result is judged at the ports: `dmaReq` must read low, the consumed flag must read set, the measured pulse width of the following periods must still show the old sample, and the new sample must appear only after the next copy. The randomized part varies period, sample, hold count and resolution. For each setting it compares measured high time and copy spacing with values the bench computes.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

  // Register word addresses on the simple bus
  typedef enum logic [2:0] {
    ADDR_SAMPLE = 3'd0,
    ADDR_PERIOD = 3'd1,
    ADDR_COUNT  = 3'd2,
    ADDR_MODE   = 3'd3,
    ADDR_FLAGS  = 3'd4
  } regAddr_e;

  // Mode word bit positions
  localparam int MODE_RUN_BIT  = 0;
  localparam int MODE_FINE_BIT = 1;
  localparam int MODE_BYTE_BIT = 2;
  localparam int MODE_HOLD_LSB = 4;

  // Flags word bit positions
  localparam int FLAG_EMPTY_BIT = 0;
  localparam int FLAG_MATCH_BIT = 1;
  localparam int EN_EMPTY_BIT   = 8;
  localparam int EN_MATCH_BIT   = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic active;   // counter running (after the start cycle)
    logic start;    // first cycle after run was set: load everything
    logic reloadA;  // copy sample staging into working sample at this wrap
    logic fine;     // half-clock resolution
    logic byteFmt;  // 8-bit sample in the upper byte
  } apwmStrobe_t;

endpackage

// File: rtl/apwm_datapath.sv
module apwm_datapath
  import apwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  apwmStrobe_t strobe,
  input  logic [W-1:0] stageA,
  input  logic [W-1:0] stageB,
  output logic [W-1:0] count,
  output logic        atEnd,
  output logic        aHit,
  output logic        pwmOut
);

  localparam int HALF_W = W / 2;
  localparam logic [W-1:0] CNT_ONE = 1;

  logic [W-1:0] cnt;
  logic [W-1:0] workA;
  logic [W-1:0] workB;
  logic [W-1:0] sampleVal;
  logic [W-1:0] cmpPoint;
  logic [W:0]   widthHalves;
  logic [W:0]   halfLo;
  logic [W:0]   halfHi;
  logic         hiFirst;
  logic         hiSecond;
  logic         posQ;
  logic         secQ;
  logic         negQ;

  assign count = cnt;

  // Effective sample: full word or upper byte
  always_comb begin
    if (strobe.byteFmt) sampleVal = {{(W - HALF_W){1'b0}}, workA[W-1:HALF_W]};
    else                sampleVal = workA;
  end

  // Compare point in counter units, pulse width in half-clock units
  always_comb begin
    if (strobe.fine) begin
      cmpPoint    = sampleVal >> 1;
      widthHalves = {1'b0, sampleVal};
    end else begin
      cmpPoint    = sampleVal;
      widthHalves = {sampleVal, 1'b0};
    end
  end

  assign halfLo   = {cnt, 1'b0};
  assign halfHi   = {cnt, 1'b1};
  assign hiFirst  = strobe.active && (halfLo < widthHalves);
  assign hiSecond = strobe.active && (halfHi < widthHalves);

  assign atEnd = strobe.active && (cnt == workB);
  assign aHit  = strobe.active && !strobe.byteFmt && (cnt == cmpPoint);

  // Counter and working registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      workA <= '0;
      workB <= '0;
    end else if (strobe.start) begin
      cnt   <= '0;
      workA <= stageA;
      workB <= stageB;
    end else if (!strobe.active) begin
      cnt <= '0;
    end else if (atEnd) begin
      cnt   <= '0;
      workB <= stageB;
      if (strobe.reloadA) workA <= stageA;
    end else begin
      cnt <= cnt + CNT_ONE;
    end
  end

  // Dual-edge output: posQ ^ negQ shows hiFirst after the rising edge
  // and hiSecond after the falling edge, one clock behind the counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= 1'b0;
      secQ <= 1'b0;
    end else begin
      posQ <= hiFirst ^ negQ;
      secQ <= hiSecond;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= secQ ^ posQ;
  end

  assign pwmOut = posQ ^ negQ;

  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |-> (cnt <= workB));

  // R11
  out_low_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.active) |-> !pwmOut);

  // R2
  start_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (cnt == '0));

endmodule

// File: rtl/apwm_ctrl.sv
module apwm_ctrl
  import apwm_pkg::*;
#(
  parameter int W     = 16,
  parameter int REP_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWe,
  input  logic [W-1:0] regWrData,
  output logic [W-1:0] regRdData,
  input  logic [W-1:0] count,
  input  logic        atEnd,
  input  logic        aHit,
  output apwmStrobe_t strobe,
  output logic [W-1:0] stageA,
  output logic [W-1:0] stageB,
  output logic        irqOut,
  output logic        dmaReq
);

  localparam logic [REP_W:0] REP_ONE = 1;

  logic             runReg;
  logic             runQ;
  logic             fineReg;
  logic             byteReg;
  logic [REP_W-1:0] holdField;
  logic [REP_W:0]   repCnt;
  logic             emptyFlag;
  logic             matchFlag;
  logic             emptyEn;
  logic             matchEn;
  logic             wrSample;
  logic             wrPeriod;
  logic             wrMode;
  logic             wrFlags;
  logic             startEv;
  logic             reloadEv;
  logic             emptySet;

  assign wrSample = regWe && (regAddr == ADDR_SAMPLE);
  assign wrPeriod = regWe && (regAddr == ADDR_PERIOD);
  assign wrMode   = regWe && (regAddr == ADDR_MODE);
  assign wrFlags  = regWe && (regAddr == ADDR_FLAGS);

  assign startEv  = runReg && !runQ;
  assign reloadEv = atEnd && (repCnt == REP_ONE);
  assign emptySet = startEv || reloadEv;

  always_comb begin
    strobe.active  = runReg && runQ;
    strobe.start   = startEv;
    strobe.reloadA = reloadEv;
    strobe.fine    = fineReg;
    strobe.byteFmt = byteReg;
  end

  // Staging and mode registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA    <= '0;
      stageB    <= '0;
      runReg    <= 1'b0;
      fineReg   <= 1'b0;
      byteReg   <= 1'b0;
      holdField <= '0;
      emptyEn   <= 1'b0;
      matchEn   <= 1'b0;
      runQ      <= 1'b0;
    end else begin
      runQ <= runReg;
      if (wrSample) stageA <= regWrData;
      if (wrPeriod) stageB <= regWrData;
      if (wrMode) begin
        runReg    <= regWrData[MODE_RUN_BIT];
        fineReg   <= regWrData[MODE_FINE_BIT];
        byteReg   <= regWrData[MODE_BYTE_BIT];
        holdField <= regWrData[MODE_HOLD_LSB +: REP_W];
      end
      if (wrFlags) begin
        emptyEn <= regWrData[EN_EMPTY_BIT];
        matchEn <= regWrData[EN_MATCH_BIT];
      end
    end
  end

  // Hold counter: periods left until the next sample copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         repCnt <= REP_ONE;
    else if (emptySet) repCnt <= {1'b0, holdField} + REP_ONE;
    else if (atEnd)    repCnt <= repCnt - REP_ONE;
  end

  // Sticky flags (set wins over clear) and refill request (write wins)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag <= 1'b0;
      matchFlag <= 1'b0;
      dmaReq    <= 1'b0;
    end else begin
      if (emptySet)                                emptyFlag <= 1'b1;
      else if (wrFlags && regWrData[FLAG_EMPTY_BIT]) emptyFlag <= 1'b0;
      if (aHit)                                    matchFlag <= 1'b1;
      else if (wrFlags && regWrData[FLAG_MATCH_BIT]) matchFlag <= 1'b0;
      if (wrSample)      dmaReq <= 1'b0;
      else if (emptySet) dmaReq <= 1'b1;
    end
  end

  assign irqOut = (emptyFlag && emptyEn) || (matchFlag && matchEn);

  // Read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_SAMPLE: regRdData = stageA;
      ADDR_PERIOD: regRdData = stageB;
      ADDR_COUNT:  regRdData = count;
      ADDR_MODE: begin
        regRdData[MODE_RUN_BIT]            = runReg;
        regRdData[MODE_FINE_BIT]           = fineReg;
        regRdData[MODE_BYTE_BIT]           = byteReg;
        regRdData[MODE_HOLD_LSB +: REP_W]  = holdField;
      end
      ADDR_FLAGS: begin
        regRdData[FLAG_EMPTY_BIT] = emptyFlag;
        regRdData[FLAG_MATCH_BIT] = matchFlag;
        regRdData[EN_EMPTY_BIT]   = emptyEn;
        regRdData[EN_MATCH_BIT]   = matchEn;
      end
      default: regRdData = '0;
    endcase
  end

  // R2
  start_sets_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> emptyFlag);

  // R7
  dma_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> emptyFlag);

  // R9
  no_match_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> !$past(byteReg));

  // R7
  hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runReg && runQ) |-> (repCnt != '0));

endmodule

// File: rtl/apwm_timer.sv
module apwm_timer
  import apwm_pkg::*;
#(
  parameter int W     = 16,
  parameter int REP_W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   regAddr,
  input  logic         regWe,
  input  logic [W-1:0] regWrData,
  output logic [W-1:0] regRdData,
  output logic         pwmOut,
  output logic         irqOut,
  output logic         dmaReq
);

  apwmStrobe_t  strobe;
  logic [W-1:0] stageA;
  logic [W-1:0] stageB;
  logic [W-1:0] count;
  logic         atEnd;
  logic         aHit;

  apwm_ctrl #(.W(W), .REP_W(REP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .count     (count),
    .atEnd     (atEnd),
    .aHit      (aHit),
    .strobe    (strobe),
    .stageA    (stageA),
    .stageB    (stageB),
    .irqOut    (irqOut),
    .dmaReq    (dmaReq)
  );

  apwm_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .stageA (stageA),
    .stageB (stageB),
    .count  (count),
    .atEnd  (atEnd),
    .aHit   (aHit),
    .pwmOut (pwmOut)
  );

endmodule

// File: tb/tb_apwm_timer.sv
module tb_apwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;
  localparam logic [2:0] A_SAMPLE = 3'd0;
  localparam logic [2:0] A_PERIOD = 3'd1;
  localparam logic [2:0] A_COUNT  = 3'd2;
  localparam logic [2:0] A_MODE   = 3'd3;
  localparam logic [2:0] A_FLAGS  = 3'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic        regWe = 1'b0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        pwmOut;
  logic        irqOut;
  logic        dmaReq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  apwm_timer dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData),
    .pwmOut(pwmOut), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measureHigh(input int clocks, output int highs);
    highs = 0;
    for (int i = 0; i < clocks; i++) begin
      @(posedge clk); #QTR; highs += int'(pwmOut);
      @(negedge clk); #QTR; highs += int'(pwmOut);
    end
  endtask

  task automatic waitDma(output int when);
    int guard = 0;
    @(negedge clk);
    while (!dmaReq && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    when = cyc;
  endtask

  function automatic int sampleOf(input int a, input bit byteFmt);
    return byteFmt ? ((a >> 8) & 255) : (a & 16'hffff);
  endfunction

  // High half-clocks per period (R4, R5, R6)
  function automatic int expHalves(input int a, input int p, input bit fine, input bit byteFmt);
    int s = sampleOf(a, byteFmt);
    if (fine) return (s < 2*(p+1)) ? s : 2*(p+1);
    return 2 * ((s < p+1) ? s : p+1);
  endfunction

  // Compare flag expectation (R9)
  function automatic bit expMatch(input int a, input int p, input bit fine, input bit byteFmt);
    int s = sampleOf(a, byteFmt);
    if (byteFmt) return 1'b0;
    return (fine ? (s >> 1) : s) <= p;
  endfunction

  function automatic logic [15:0] modeWord(input bit run, input bit fine, input bit byteFmt, input int hold);
    logic [15:0] m = 16'd0;
    m[0] = run; m[1] = fine; m[2] = byteFmt;
    m[7:4] = 4'(hold - 1);
    return m;
  endfunction

  // Configure, start and check width, compare flag and copy spacing
  task automatic runCase(input int a, input int p, input bit fine, input bit byteFmt, input int hold);
    int highs, t0, t1;
    logic [15:0] d;
    wr(A_MODE, 16'd0);
    wr(A_SAMPLE, 16'(a));
    wr(A_PERIOD, 16'(p));
    wr(A_MODE, modeWord(1'b1, fine, byteFmt, hold));
    idle(2*(p+1) + 4);
    measureHigh(3*(p+1), highs);
    if (fine) chk(highs == 3*expHalves(a, p, fine, byteFmt), byteFmt ? "R6 fine width" : "R5 fine width",
                  highs, 3*expHalves(a, p, fine, byteFmt));
    else      chk(highs == 3*expHalves(a, p, fine, byteFmt), byteFmt ? "R6 byte width" : "R4 normal width",
                  highs, 3*expHalves(a, p, fine, byteFmt));
    wr(A_FLAGS, 16'h0003);
    idle(p + 3);
    rd(A_FLAGS, d);
    chk(d[1] == expMatch(a, p, fine, byteFmt), "R9 compare flag", d[1], expMatch(a, p, fine, byteFmt));
    wr(A_SAMPLE, 16'(a));
    waitDma(t0);
    wr(A_SAMPLE, 16'(a));
    waitDma(t1);
    chk(t1 - t0 == hold*(p+1), "R7 copy spacing", t1 - t0, hold*(p+1));
  endtask

  initial begin
    logic [15:0] d;
    int highs, k, maxBefore, maxAfter;
    bit wrapped;
    void'($urandom(32'd4711));

    // R1 reset state
    idle(3);
    rstN = 1'b1;
    idle(1);
    rd(A_COUNT, d);
    chk(d == 16'd0, "R1 count", d, 0);
    chk(!pwmOut && !irqOut && !dmaReq, "R1 outputs", {pwmOut, irqOut, dmaReq}, 0);

    // R2 start copies, sets flag and request, counter from 0
    wr(A_SAMPLE, 16'd5);
    wr(A_PERIOD, 16'd20);
    wr(A_FLAGS, 16'h0100);
    wr(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 16));
    @(negedge clk);
    rd(A_COUNT, d);
    chk(d == 16'd0, "R2 counter restart", d, 0);
    chk(dmaReq == 1'b1, "R2 dma raised", dmaReq, 1);
    rd(A_FLAGS, d);
    chk(d[0] == 1'b1, "R2 consumed flag", d[0], 1);
    // R10 interrupt gating
    chk(irqOut == 1'b1, "R10 irq from consumed", irqOut, 1);
    idle(8);
    wr(A_FLAGS, 16'h0001);
    rd(A_FLAGS, d);
    chk(d[0] == 1'b0 && d[1] == 1'b1, "R10 w1c consumed only", d[1:0], 2);
    chk(irqOut == 1'b0, "R10 irq masked", irqOut, 0);
    wr(A_FLAGS, 16'h0200);
    chk(irqOut == 1'b1, "R10 irq from compare", irqOut, 1);
    wr(A_FLAGS, 16'h0002);
    chk(irqOut == 1'b0, "R10 irq after clear", irqOut, 0);

    // R11 stop
    wr(A_MODE, 16'd0);
    idle(2);
    rd(A_COUNT, d);
    chk(d == 16'd0, "R11 counter reset", d, 0);
    measureHigh(12, highs);
    chk(highs == 0, "R11 output low", highs, 0);

    // R3 period buffered until wrap
    wr(A_PERIOD, 16'd9);
    wr(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 1));
    regAddr = A_COUNT;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (regRdData == 16'd1) break;
    end
    wr(A_PERIOD, 16'd4);
    regAddr = A_COUNT;
    maxBefore = 0; maxAfter = 0; wrapped = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (regRdData == 16'd0) wrapped = 1'b1;
      if (!wrapped && int'(regRdData) > maxBefore) maxBefore = int'(regRdData);
      if (wrapped && int'(regRdData) > maxAfter) maxAfter = int'(regRdData);
      @(negedge clk);
    end
    chk(maxBefore == 9, "R3 old period completes", maxBefore, 9);
    chk(maxAfter == 4, "R3 new period at wrap", maxAfter, 4);

    // Directed corners: saturation, zero, byte low bits ignored
    runCase(100, 5, 1'b0, 1'b0, 1);
    runCase(0, 7, 1'b0, 1'b0, 2);
    runCase(7, 6, 1'b1, 1'b0, 1);
    runCase(16'h03ff, 8, 1'b0, 1'b1, 3);

    // R8 sample write on the same edge as a copy
    wr(A_MODE, 16'd0);
    wr(A_SAMPLE, 16'd3);
    wr(A_PERIOD, 16'd9);
    wr(A_MODE, modeWord(1'b1, 1'b0, 1'b0, 2));
    idle(3);
    wr(A_SAMPLE, 16'd3);
    waitDma(k);
    wr(A_FLAGS, 16'h0001);
    while (cyc < k + 18) @(negedge clk);
    wr(A_SAMPLE, 16'd7);
    chk(dmaReq == 1'b0, "R8 write wins request", dmaReq, 0);
    rd(A_FLAGS, d);
    chk(d[0] == 1'b1, "R8 consumed flag set", d[0], 1);
    rd(A_SAMPLE, d);
    chk(d == 16'd7, "R8 new value staged", d, 7);
    measureHigh(10, highs);
    chk(highs == 6, "R8 copy took old sample", highs, 6);
    while (cyc < k + 42) @(negedge clk);
    measureHigh(10, highs);
    chk(highs == 14, "R8 new sample at next copy", highs, 14);

    // Constrained random settings
    for (int it = 0; it < 10; it++) begin
      int p, a, s, lim, hold;
      bit fine, byteFmt;
      p = 3 + int'($urandom % 28);
      fine = 1'($urandom % 2);
      byteFmt = (($urandom % 3) == 0);
      hold = 1 + int'($urandom % 4);
      lim = fine ? 2*(p+1) + 3 : p + 4;
      s = int'($urandom % lim);
      a = byteFmt ? ((s << 8) | int'($urandom % 256)) : s;
      runCase(a, p, fine, byteFmt, hold);
    end

    wr(A_MODE, 16'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule